// File: doc/BRIEF.md
# Serial Audio Sample Input Register

This block receives audio samples over a three-wire serial link (a data line, a bit clock and an active-low latch strobe) and presents a parallel sample to a converter core. All three link inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer. The bit clock and the latch strobe then go through edge detection. The system clock must run at least four times faster than the fastest bit clock.

Bits enter a shift register most significant bit first, one on each rising bit-clock edge. A separate holding register drives the parallel output. It changes only when the latch strobe goes low, never when the bit count completes on its own. A saturating bit counter tracks how many bits arrived since the last latch. A sticky flag reports any latch that does not follow exactly one full word. The word length is a parameter of 16 or 18.

Top module: `sdac_rx`

## Requirements
- R1: After reset, sample_o is all zeros (the midscale two's-complement code), sample_valid_o is 0 and framing_error_o is 0.
- R2: Each rising edge of sclk_i captures sdata_i into the shift register. After WORD_W bits and a latch, sample_o holds the word with the first bit received in bit WORD_W-1 and the last bit received in bit 0.
- R3: sample_o keeps its value while bits are shifted in. It takes the shift register contents only on a falling edge of latch_ni, and the new value is visible exactly 3 system-clock cycles after latch_ni falls.
- R4: sample_valid_o is high for exactly one system-clock cycle, in the same cycle that sample_o takes each new value.
- R5: When more than WORD_W bits arrive before a latch, the earlier bits shift out of the top of the register and the last WORD_W bits are loaded.
- R6: When latch_ni falls and the bit count since the previous latch (or reset) is not exactly WORD_W, sample_o still loads the shift register contents and framing_error_o goes to 1.
- R7: framing_error_o stays at 1 until reset and is never set by a latch that follows exactly WORD_W bits. The bit counter restarts from zero on every falling edge of latch_ni.
- R8: A rising edge of latch_ni has no effect: it produces no sample_valid_o pulse and no change of sample_o.
- R9: sdata_i changes that do not coincide with a rising sclk_i edge are ignored, including changes while sclk_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first, asynchronous |
| latch_ni | input | 1 | Active-low latch strobe, asynchronous |
| sample_o | output | WORD_W | Parallel sample to the converter core |
| sample_valid_o | output | 1 | One-cycle pulse marking each sample update |
| framing_error_o | output | 1 | Sticky flag for a latch after a wrong bit count |

## Verification
A falling latch strobe passes two synchronizer stages and the edge detector, and then loads the holding register. The sample, the valid pulse and the framing flag are therefore due on the third system-clock edge after latch_ni drops. The driver records that cycle number with each expected item it queues. The monitor samples at the falling system-clock edge and checks that each valid pulse arrives in exactly the recorded cycle and carries the queued word and flag. Between latches the bench checks that sample_o has not moved, and a valid pulse with nothing queued counts as a failure.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  localparam int unsigned SYNC_STAGES_MIN = 2;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
  import sdac_pkg::*;
#(
  parameter edge_sel_e SEL     = EDGE_RISE,
  parameter logic      RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= level_i;
  end

  generate
    if (SEL == EDGE_RISE) begin : g_rise
      assign edge_o = level_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~level_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_MAX = WORD_W + 1,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] shift_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      // oldest bits fall off the top
      if (shift_i) shift_q <= {shift_q[WORD_W-2:0], bit_i};
      if (clr_i)                                   cnt_q <= '0;
      else if (shift_i && cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shift_o = shift_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              frame_ok_i,
  output logic [WORD_W-1:0] sample_o,
  output logic              valid_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i)                err_o    <= err_o | ~frame_ok_i;
      if (load_i)                sample_o <= data_i;
    end
  end
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
  import sdac_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(WORD_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              latch_ni,
  output logic [WORD_W-1:0] sample_o,
  output logic              sample_valid_o,
  output logic              framing_error_o
);
  initial begin
    if (SYNC_STAGES < SYNC_STAGES_MIN) $error("SYNC_STAGES too small");
    if (WORD_W != 16 && WORD_W != 18)  $error("WORD_W must be 16 or 18");
  end

  logic sclk_s, sdata_s, latch_s;
  logic sclk_rise, latch_fall;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt;

  sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i, .rst_ni, .async_i(sclk_i), .sync_o(sclk_s));
  sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_data (
    .clk_i, .rst_ni, .async_i(sdata_i), .sync_o(sdata_s));
  sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_latch (
    .clk_i, .rst_ni, .async_i(latch_ni), .sync_o(latch_s));

  sdac_edge #(.SEL(EDGE_RISE), .RST_VAL(1'b0)) u_edge_sclk (
    .clk_i, .rst_ni, .level_i(sclk_s), .edge_o(sclk_rise));
  sdac_edge #(.SEL(EDGE_FALL), .RST_VAL(1'b1)) u_edge_latch (
    .clk_i, .rst_ni, .level_i(latch_s), .edge_o(latch_fall));

  sdac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni,
    .shift_i (sclk_rise),
    .bit_i   (sdata_s),
    .clr_i   (latch_fall),
    .shift_o (shift_q),
    .cnt_o   (bit_cnt)
  );

  sdac_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i, .rst_ni,
    .load_i     (latch_fall),
    .data_i     (shift_q),
    .frame_ok_i (bit_cnt == CNT_W'(WORD_W)),
    .sample_o   (sample_o),
    .valid_o    (sample_valid_o),
    .err_o      (framing_error_o)
  );
endmodule

module sdac_rx_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_rise,
  input logic              latch_fall,
  input logic [WORD_W-1:0] shift_q,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] sample_o,
  input logic              sample_valid_o,
  input logic              framing_error_o
);
  // R3
  sample_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_fall |=> sample_o == $past(shift_q));
  // R3
  sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_fall |=> $stable(sample_o));
  // R4
  valid_follows_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_fall |=> sample_valid_o);
  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);
  // R6
  framing_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_fall && bit_cnt != CNT_W'(WORD_W) |=> framing_error_o);
  // R7
  framing_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    framing_error_o |=> framing_error_o);
  // R7
  framing_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !framing_error_o && !(latch_fall && bit_cnt != CNT_W'(WORD_W)) |=> !framing_error_o);
  // R7
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_fall |=> bit_cnt == '0);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise && !latch_fall && bit_cnt < CNT_W'(WORD_W + 1) |=> bit_cnt == $past(bit_cnt) + 1'b1);
endmodule

bind sdac_rx sdac_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sclk_rise       (sclk_rise),
  .latch_fall      (latch_fall),
  .shift_q         (shift_q),
  .bit_cnt         (bit_cnt),
  .sample_o        (sample_o),
  .sample_valid_o  (sample_valid_o),
  .framing_error_o (framing_error_o)
);

// File: tb/sdac_rx_test.sv
module sdac_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    logic [W-1:0] data;
    logic         err;
    int           due;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, latch_n = 1'b1;
  logic [W-1:0] sample;
  logic valid, ferr;

  int checks = 0, failures = 0, cyc = 0, unexpected = 0;
  bit done = 1'b0;
  exp_t q[$];

  logic [W-1:0] m_shift = '0;
  int           m_cnt = 0;
  logic         m_err = 1'b0;
  logic [W-1:0] last_sample;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdac_rx #(.WORD_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .latch_ni(latch_n), .sample_o(sample), .sample_valid_o(valid),
    .framing_error_o(ferr));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: data toggles while sclk is high must not be captured
  task automatic send_bit(input logic b);
    sdata = b; sclk = 1'b0; tick(3);
    sclk = 1'b1;
    m_shift = {m_shift[W-2:0], b};
    if (m_cnt < W + 1) m_cnt++;
    tick(2);
    sdata = ~b; tick(1);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    sclk = 1'b0; tick(3);
  endtask

  task automatic latch();
    exp_t e;
    m_err  = m_err | (m_cnt != W);
    e.data = m_shift; e.err = m_err; e.due = cyc + 3;
    q.push_back(e);
    m_cnt  = 0;
    latch_n = 1'b0; tick(5);
    latch_n = 1'b1; tick(5);   // R8: rising edge must not pulse valid
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && valid) begin
      if (q.size() == 0) begin
        unexpected++;
        failures++;
        $display("FAIL R8 actual=valid expected=no_valid cycle=%0d", cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R2/R5 sample", sample, e.data);
        chk("R6/R7 framing", W'(ferr), W'(e.err));
        chk("R3/R4 timing", W'(cyc), W'(e.due));
      end
    end
  end

  task automatic word(input logic [31:0] v);
    last_sample = sample;
    send_bits(v, W);
    chk("R3 hold before latch", sample, last_sample);
    latch();
    chk("R4 single pulse", W'(valid), '0);
  endtask

  initial begin
    tick(3);
    chk("R1 sample", sample, '0);
    chk("R1 valid", W'(valid), '0);
    chk("R1 framing", W'(ferr), '0);
    rst_ni = 1'b1;
    tick(3);

    word(32'hA5C3);
    word(32'h0001);
    word(32'hFFFF);
    word(32'h8000);
    word(32'h3C96);
    chk("R7 clean frames", W'(ferr), '0);

    // R5: overlong word keeps last W bits
    send_bits(32'h5_1234, W + 3);
    latch();
    chk("R5 sample", sample, W'(32'h1234 | (32'h5 << 16)));

    // R6: short word still loads
    send_bits(32'h15, 5);
    latch();
    chk("R6 framing", W'(ferr), W'(1));

    word(32'h7E81);
    chk("R7 sticky", W'(ferr), W'(1));

    // R7: reset clears flag
    rst_ni = 1'b0; tick(2);
    chk("R7 reset flag", W'(ferr), '0);
    chk("R1 reset sample", sample, '0);
    m_shift = '0; m_cnt = 0; m_err = 1'b0;
    rst_ni = 1'b1; tick(3);
    word(32'hC0DE);
    chk("R7 clean after reset", W'(ferr), '0);

    tick(10);
    chk("R4 queue drained", W'(q.size()), '0);
    chk("R8 no stray valid", W'(unexpected), '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule